// File: doc/BRIEF.md
# TDM Subrate Channel Bit Extractor and Inserter

This block sits beside a set of framed time-division-multiplexed serial links. It picks out the bits that belong to individual data-link channels and hands each one on with its channel number. In the other direction it fills the matching bit positions on the links with bits taken from each channel's transmit source. Each link gives, for every bit position, a valid strobe, the serial bit, the bit index inside the time slot, the time-slot index and a flag that marks odd frames. HDLC framing, flag detection, bit stuffing and CRC belong to the consumer and are not part of this block.

Each of up to 64 channels has one receive configuration and one transmit configuration, and the two are independent. A configuration names a link, a time slot in that link, a mask of the slot's bits that belong to the channel, and a frame selector for even frames, odd frames or both. A channel's bandwidth therefore runs from one bit every other frame up to the whole slot in every frame. Configuration is written through a simple write port. A new setting is held back until the first bit of the next frame on its link, so a channel never sees a frame that mixes old and new settings.

Top module: `tdm_subrate_xtract`

## Requirements
- R1: After reset, `rx_vld_o` and `tx_take_o` are all zero, every `tx_bit_o` is 1, and every channel is inactive in both directions.
- R2: Writes decode `cfg_addr_i` as follows. Bit 7 selects the set (0 = receive, 1 = transmit), bits 6:1 give the channel, and bit 0 gives the register. Register 0 holds the slot in data bits 12:8 and the mask in bits 7:0. Register 1 holds the frame selector in bits 15:14 and the link in bits 4:0. All other data bits are ignored.
- R3: Mask bit 7 covers bit index 0, which is the first bit of the slot in time. In general mask bit 7-k covers bit index k. A bit is taken only when its mask bit is 1.
- R4: Frame selector 00 takes nothing, 01 takes only even frames (`odd_frame_i`=0), 10 takes only odd frames, and 11 takes every frame.
- R5: A channel matches only positions on its own link number and its own slot number.
- R6: A receive match on link l makes `rx_vld_o[l]` high for one cycle, one clock after the position. `rx_ch_o` then carries the channel number and `rx_bit_o` the sampled bit. A position that matches no channel gives no strobe.
- R7: When several channels match the same position, the lowest-numbered channel takes the bit.
- R8: A transmit match whose source has `tx_rdy_i` set raises that channel's `tx_take_o` in the same cycle. One clock later `tx_bit_o[l]` equals the source's `tx_data_i`.
- R9: An unmatched position, or a matched one whose source is not ready, gives `tx_bit_o[l]`=1 one clock later and no take. No position at all also gives 1.
- R10: A written setting takes effect at the next position with slot 0 and bit index 0 on the setting's link, and that position already uses it. A setting with frame selector 00, or with a link number of at least NUM_LINKS, takes effect on the cycle after the write.
- R11: Receive and transmit configurations are independent. A transmit setting never produces a receive strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Set, channel and register select |
| cfg_wdata_i | input | 16 | Configuration write data |
| pos_vld_i | input | NUM_LINKS | Bit position present, one per link |
| slot_idx_i | input | 5*NUM_LINKS | Time-slot index, per link |
| bit_idx_i | input | 3*NUM_LINKS | Bit index inside the slot, per link |
| odd_frame_i | input | NUM_LINKS | Current frame is odd, per link |
| rx_bit_i | input | NUM_LINKS | Received serial bit, per link |
| rx_vld_o | output | NUM_LINKS | Extracted bit strobe, per link |
| rx_ch_o | output | 6*NUM_LINKS | Channel of the extracted bit, per link |
| rx_bit_o | output | NUM_LINKS | Extracted bit value, per link |
| tx_rdy_i | input | NUM_CH | Transmit source has a bit, per channel |
| tx_data_i | input | NUM_CH | Transmit source bit, per channel |
| tx_take_o | output | NUM_CH | Transmit bit consumed, per channel |
| tx_bit_o | output | NUM_LINKS | Outgoing serial bit, per link |

## Verification
If a held-back setting is lost or committed at the wrong time, a strobe appears or goes missing at the very next position of that channel's slot. It shows before or after the frame's first bit, within the same frame. A wrong priority order or mask bit order shows on `rx_ch_o` one clock after the position that reveals it. A transmit path that selects the wrong source or drops readiness shows on `tx_bit_o` one clock after the position, and on `tx_take_o` in the same cycle. The directed scenarios put each of these cases on the ports before and after a frame boundary.

// File: rtl/tdm_sub_pkg.sv
package tdm_sub_pkg;
  localparam int SLOT_W = 5;
  localparam int LINK_W = 5;
  localparam int MASK_W = 8;
  localparam int BIT_W  = 3;
  localparam int FSEL_W = 2;
  localparam int REG_W  = 16;

  typedef struct packed {
    logic [FSEL_W-1:0] fsel;
    logic [LINK_W-1:0] link;
    logic [SLOT_W-1:0] slot;
    logic [MASK_W-1:0] mask;
  } chan_cfg_t;

  function automatic logic frame_ok(logic [FSEL_W-1:0] fsel, logic odd);
    return odd ? fsel[1] : fsel[0];
  endfunction
endpackage

// File: rtl/tdm_sub_cfg_bank.sv
module tdm_sub_cfg_bank
  import tdm_sub_pkg::*;
#(
  parameter int NUM_CH    = 64,
  parameter int NUM_LINKS = 4,
  localparam int CH_W     = $clog2(NUM_CH)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [CH_W-1:0]        wr_ch_i,
  input  logic                   wr_sel_i,
  input  logic [REG_W-1:0]       wr_data_i,
  input  logic [NUM_LINKS-1:0]   bnd_i,
  output chan_cfg_t              eff_o [NUM_CH]
);
  chan_cfg_t shadow_q [NUM_CH];
  chan_cfg_t active_q [NUM_CH];
  logic [NUM_CH-1:0] pend_q;

  logic unused_rsvd;
  assign unused_rsvd = wr_data_i[13];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic wr_hit, link_ok, bnd_sel, commit;

    assign wr_hit  = wr_en_i && (wr_ch_i == CH_W'(c));
    assign link_ok = shadow_q[c].link < LINK_W'(NUM_LINKS);

    always_comb begin
      bnd_sel = 1'b0;
      for (int l = 0; l < NUM_LINKS; l++)
        if (shadow_q[c].link == LINK_W'(l)) bnd_sel = bnd_i[l];
    end

    // a disabled or unreachable setting cannot split a frame, so it applies at once
    assign commit = pend_q[c] && !wr_hit &&
                    ((shadow_q[c].fsel == '0) || !link_ok || bnd_sel);
    assign eff_o[c] = commit ? shadow_q[c] : active_q[c];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q[c] <= '0;
        active_q[c] <= '0;
        pend_q[c]   <= 1'b0;
      end else begin
        active_q[c] <= eff_o[c];
        if (wr_hit) begin
          pend_q[c] <= 1'b1;
          if (wr_sel_i) begin
            shadow_q[c].fsel <= wr_data_i[15:14];
            shadow_q[c].link <= wr_data_i[LINK_W-1:0];
          end else begin
            shadow_q[c].slot <= wr_data_i[8+:SLOT_W];
            shadow_q[c].mask <= wr_data_i[MASK_W-1:0];
          end
        end else if (commit) begin
          pend_q[c] <= 1'b0;
        end
      end
    end

    assert_active_needs_pend_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_q[c] != $past(active_q[c])) |-> $past(pend_q[c]));
  end
endmodule

// File: rtl/tdm_sub_match.sv
module tdm_sub_match
  import tdm_sub_pkg::*;
#(
  parameter int NUM_CH  = 64,
  parameter int LINK_ID = 0,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  chan_cfg_t          cfg_i [NUM_CH],
  input  logic               pos_vld_i,
  input  logic [SLOT_W-1:0]  slot_i,
  input  logic [BIT_W-1:0]   bit_i,
  input  logic               odd_i,
  output logic               hit_o,
  output logic [CH_W-1:0]    ch_o
);
  logic [NUM_CH-1:0] m;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
    // mask bit 7 is the first bit of the slot
    assign m[c] = pos_vld_i &&
                  (cfg_i[c].link == LINK_W'(LINK_ID)) &&
                  (cfg_i[c].slot == slot_i) &&
                  cfg_i[c].mask[~bit_i] &&
                  frame_ok(cfg_i[c].fsel, odd_i);
  end

  always_comb begin
    hit_o = 1'b0;
    ch_o  = '0;
    for (int c = NUM_CH - 1; c >= 0; c--)
      if (m[c]) begin
        hit_o = 1'b1;
        ch_o  = CH_W'(c);
      end
  end
endmodule

// File: rtl/tdm_subrate_xtract.sv
module tdm_subrate_xtract
  import tdm_sub_pkg::*;
#(
  parameter int NUM_CH    = 64,
  parameter int NUM_LINKS = 4,
  localparam int CH_W     = $clog2(NUM_CH),
  localparam int ADDR_W   = CH_W + 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cfg_we_i,
  input  logic [ADDR_W-1:0]           cfg_addr_i,
  input  logic [REG_W-1:0]            cfg_wdata_i,
  input  logic [NUM_LINKS-1:0]        pos_vld_i,
  input  logic [SLOT_W*NUM_LINKS-1:0] slot_idx_i,
  input  logic [BIT_W*NUM_LINKS-1:0]  bit_idx_i,
  input  logic [NUM_LINKS-1:0]        odd_frame_i,
  input  logic [NUM_LINKS-1:0]        rx_bit_i,
  output logic [NUM_LINKS-1:0]        rx_vld_o,
  output logic [CH_W*NUM_LINKS-1:0]   rx_ch_o,
  output logic [NUM_LINKS-1:0]        rx_bit_o,
  input  logic [NUM_CH-1:0]           tx_rdy_i,
  input  logic [NUM_CH-1:0]           tx_data_i,
  output logic [NUM_CH-1:0]           tx_take_o,
  output logic [NUM_LINKS-1:0]        tx_bit_o
);
  logic            wr_tx;
  logic [CH_W-1:0] wr_ch;
  logic            wr_sel;
  assign wr_tx  = cfg_addr_i[ADDR_W-1];
  assign wr_ch  = cfg_addr_i[ADDR_W-2:1];
  assign wr_sel = cfg_addr_i[0];

  logic [NUM_LINKS-1:0] bnd;
  for (genvar l = 0; l < NUM_LINKS; l++) begin : g_bnd
    assign bnd[l] = pos_vld_i[l] && (slot_idx_i[l*SLOT_W+:SLOT_W] == '0) &&
                    (bit_idx_i[l*BIT_W+:BIT_W] == '0);
  end

  chan_cfg_t rx_cfg [NUM_CH];
  chan_cfg_t tx_cfg [NUM_CH];

  tdm_sub_cfg_bank #(.NUM_CH(NUM_CH), .NUM_LINKS(NUM_LINKS)) u_rx_bank (
    .clk_i, .rst_ni,
    .wr_en_i(cfg_we_i && !wr_tx), .wr_ch_i(wr_ch), .wr_sel_i(wr_sel),
    .wr_data_i(cfg_wdata_i), .bnd_i(bnd), .eff_o(rx_cfg));

  tdm_sub_cfg_bank #(.NUM_CH(NUM_CH), .NUM_LINKS(NUM_LINKS)) u_tx_bank (
    .clk_i, .rst_ni,
    .wr_en_i(cfg_we_i && wr_tx), .wr_ch_i(wr_ch), .wr_sel_i(wr_sel),
    .wr_data_i(cfg_wdata_i), .bnd_i(bnd), .eff_o(tx_cfg));

  logic [NUM_LINKS-1:0] rx_hit, tx_hit;
  logic [CH_W-1:0]      rx_ch [NUM_LINKS];
  logic [CH_W-1:0]      tx_ch [NUM_LINKS];
  logic [NUM_LINKS-1:0] rx_vld_q, rx_bit_q, tx_bit_q;
  logic [CH_W-1:0]      rx_ch_q [NUM_LINKS];

  for (genvar l = 0; l < NUM_LINKS; l++) begin : g_link
    tdm_sub_match #(.NUM_CH(NUM_CH), .LINK_ID(l)) u_rx_match (
      .cfg_i(rx_cfg), .pos_vld_i(pos_vld_i[l]),
      .slot_i(slot_idx_i[l*SLOT_W+:SLOT_W]), .bit_i(bit_idx_i[l*BIT_W+:BIT_W]),
      .odd_i(odd_frame_i[l]), .hit_o(rx_hit[l]), .ch_o(rx_ch[l]));

    tdm_sub_match #(.NUM_CH(NUM_CH), .LINK_ID(l)) u_tx_match (
      .cfg_i(tx_cfg), .pos_vld_i(pos_vld_i[l]),
      .slot_i(slot_idx_i[l*SLOT_W+:SLOT_W]), .bit_i(bit_idx_i[l*BIT_W+:BIT_W]),
      .odd_i(odd_frame_i[l]), .hit_o(tx_hit[l]), .ch_o(tx_ch[l]));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rx_vld_q[l] <= 1'b0;
        rx_bit_q[l] <= 1'b0;
        rx_ch_q[l]  <= '0;
        tx_bit_q[l] <= 1'b1;
      end else begin
        rx_vld_q[l] <= rx_hit[l];
        rx_bit_q[l] <= rx_hit[l] && rx_bit_i[l];
        rx_ch_q[l]  <= rx_hit[l] ? rx_ch[l] : '0;
        tx_bit_q[l] <= (tx_hit[l] && tx_rdy_i[tx_ch[l]]) ? tx_data_i[tx_ch[l]] : 1'b1;
      end
    end

    assign rx_vld_o[l]             = rx_vld_q[l];
    assign rx_bit_o[l]             = rx_bit_q[l];
    assign rx_ch_o[l*CH_W+:CH_W]   = rx_ch_q[l];
    assign tx_bit_o[l]             = tx_bit_q[l];

    assert_rx_after_pos_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_vld_o[l] |-> $past(pos_vld_i[l]));
    assert_tx_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(pos_vld_i[l]) |-> tx_bit_o[l]);
  end

  // each channel lives on one link, so at most one take per channel per cycle
  always_comb begin
    tx_take_o = '0;
    for (int l = 0; l < NUM_LINKS; l++)
      if (tx_hit[l] && tx_rdy_i[tx_ch[l]]) tx_take_o[tx_ch[l]] = 1'b1;
  end

  assert_take_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(tx_take_o) <= NUM_LINKS);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_take_chk
    assert_take_drives_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tx_take_o[c] && !tx_data_i[c]) |=> !(&tx_bit_o));
  end
endmodule

// File: tb/tdm_subrate_xtract_tb_top.sv
module tdm_subrate_xtract_tb_top;
  localparam int NCH = 64;
  localparam int NL  = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk_i = ~clk_i;

  logic          cfg_we_i = 1'b0;
  logic [7:0]    cfg_addr_i = '0;
  logic [15:0]   cfg_wdata_i = '0;
  logic [NL-1:0] pos_vld_i = '0;
  logic [5*NL-1:0] slot_idx_i = '0;
  logic [3*NL-1:0] bit_idx_i = '0;
  logic [NL-1:0] odd_frame_i = '0;
  logic [NL-1:0] rx_bit_i = '0;
  logic [NL-1:0] rx_vld_o;
  logic [6*NL-1:0] rx_ch_o;
  logic [NL-1:0] rx_bit_o;
  logic [NCH-1:0] tx_rdy_i = '0;
  logic [NCH-1:0] tx_data_i = '0;
  logic [NCH-1:0] tx_take_o;
  logic [NL-1:0] tx_bit_o;

  tdm_subrate_xtract #(.NUM_CH(NCH), .NUM_LINKS(NL)) dut_i (.*);

  int n_chk = 0;
  int n_err = 0;
  logic [NCH-1:0] take_s;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(bit tx, int ch, bit sel, logic [15:0] d);
    cfg_we_i = 1'b1; cfg_addr_i = {tx, 6'(ch), sel}; cfg_wdata_i = d;
    @(posedge clk_i); #1;
    cfg_we_i = 1'b0;
  endtask

  task automatic setup(bit tx, int ch, int link, int slot, logic [7:0] mask, logic [1:0] fs);
    wr(tx, ch, 1'b0, {3'b000, 5'(slot), mask});
    wr(tx, ch, 1'b1, {fs, 9'h000, 5'(link)});
  endtask

  // one position on one link; outputs sampled one clock later
  task automatic pos(int l, int slot, int b, bit odd, bit d);
    pos_vld_i[l] = 1'b1; slot_idx_i[l*5+:5] = 5'(slot);
    bit_idx_i[l*3+:3] = 3'(b); odd_frame_i[l] = odd; rx_bit_i[l] = d;
    #2; take_s = tx_take_o;
    @(posedge clk_i); #1;
    pos_vld_i = '0;
  endtask

  task automatic expect_rx(string tag, int l, bit vld, int ch, bit d);
    chk({tag, " vld"}, int'(rx_vld_o[l]), int'(vld));
    if (vld) begin
      chk({tag, " ch"}, int'(rx_ch_o[l*6+:6]), ch);
      chk({tag, " bit"}, int'(rx_bit_o[l]), int'(d));
    end
  endtask

  task automatic t_reset();
    chk("R1 rx_vld", int'(rx_vld_o), 0);
    chk("R1 tx_bit", int'(tx_bit_o), 15);
    chk("R1 take", int'(tx_take_o != '0), 0);
    pos(1, 3, 0, 1'b0, 1'b1);
    expect_rx("R1 inactive", 1, 1'b0, 0, 1'b0);
  endtask

  task automatic t_mask_link();
    // reserved data bits set, must be ignored (R2)
    wr(1'b0, 5, 1'b0, {3'b111, 5'd3, 8'b1010_0000});
    wr(1'b0, 5, 1'b1, {2'b11, 9'h1FF, 5'd1});
    pos(1, 3, 0, 1'b0, 1'b1);
    expect_rx("R10 before boundary", 1, 1'b0, 0, 1'b0);
    pos(1, 0, 0, 1'b0, 1'b0);
    expect_rx("R6 boundary no match", 1, 1'b0, 0, 1'b0);
    pos(1, 3, 0, 1'b0, 1'b1);
    expect_rx("R3 R2 first bit", 1, 1'b1, 5, 1'b1);
    pos(1, 3, 1, 1'b0, 1'b1);
    expect_rx("R3 unmasked bit", 1, 1'b0, 0, 1'b0);
    pos(1, 3, 2, 1'b1, 1'b0);
    expect_rx("R3 third bit", 1, 1'b1, 5, 1'b0);
    pos(1, 3, 7, 1'b0, 1'b1);
    expect_rx("R3 last bit", 1, 1'b0, 0, 1'b0);
    pos(0, 3, 0, 1'b0, 1'b1);
    expect_rx("R5 wrong link", 0, 1'b0, 0, 1'b0);
    pos(1, 4, 0, 1'b0, 1'b1);
    expect_rx("R5 wrong slot", 1, 1'b0, 0, 1'b0);
  endtask

  task automatic t_frame_sel();
    wr(1'b0, 5, 1'b1, {2'b01, 9'h000, 5'd1});
    pos(1, 3, 0, 1'b1, 1'b1);
    expect_rx("R10 old sel odd", 1, 1'b1, 5, 1'b1);
    pos(1, 0, 0, 1'b0, 1'b0);
    pos(1, 3, 0, 1'b1, 1'b1);
    expect_rx("R4 even-only odd frame", 1, 1'b0, 0, 1'b0);
    pos(1, 3, 0, 1'b0, 1'b1);
    expect_rx("R4 even-only even frame", 1, 1'b1, 5, 1'b1);
    wr(1'b0, 5, 1'b1, {2'b10, 9'h000, 5'd1});
    pos(1, 0, 0, 1'b1, 1'b0);
    pos(1, 3, 0, 1'b0, 1'b1);
    expect_rx("R4 odd-only even frame", 1, 1'b0, 0, 1'b0);
    pos(1, 3, 0, 1'b1, 1'b0);
    expect_rx("R4 odd-only odd frame", 1, 1'b1, 5, 1'b0);
    wr(1'b0, 5, 1'b1, {2'b00, 9'h000, 5'd1});
    pos(1, 3, 0, 1'b1, 1'b1);
    expect_rx("R4 R10 off at once", 1, 1'b0, 0, 1'b0);
  endtask

  task automatic t_priority();
    setup(1'b0, 9, 2, 7, 8'hFF, 2'b11);
    setup(1'b0, 2, 2, 7, 8'hFF, 2'b11);
    pos(2, 0, 0, 1'b0, 1'b0);
    pos(2, 7, 4, 1'b0, 1'b1);
    expect_rx("R7 lowest wins", 2, 1'b1, 2, 1'b1);
    wr(1'b0, 2, 1'b1, {2'b00, 9'h000, 5'd2});
    pos(2, 7, 5, 1'b1, 1'b0);
    expect_rx("R7 next channel", 2, 1'b1, 9, 1'b0);
  endtask

  task automatic t_tx();
    setup(1'b1, 10, 0, 1, 8'h80, 2'b11);
    tx_rdy_i[10] = 1'b1; tx_data_i[10] = 1'b0;
    pos(0, 0, 0, 1'b0, 1'b0);
    pos(0, 1, 0, 1'b0, 1'b0);
    chk("R8 take", int'(take_s[10]), 1);
    chk("R8 tx bit", int'(tx_bit_o[0]), 0);
    expect_rx("R11 no rx strobe", 0, 1'b0, 0, 1'b0);
    tx_rdy_i[10] = 1'b0;
    pos(0, 1, 0, 1'b0, 1'b0);
    chk("R9 not ready take", int'(take_s[10]), 0);
    chk("R9 not ready bit", int'(tx_bit_o[0]), 1);
    tx_rdy_i[10] = 1'b1;
    pos(0, 1, 3, 1'b0, 1'b0);
    chk("R9 unmatched take", int'(take_s != '0), 0);
    chk("R9 unmatched bit", int'(tx_bit_o[0]), 1);
    tx_data_i[10] = 1'b1;
    pos(0, 1, 0, 1'b1, 1'b0);
    chk("R8 tx one", int'(tx_bit_o[0]), 1);
    chk("R8 take again", int'(take_s[10]), 1);
    tx_rdy_i = '0;
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #5 rst_ni = 1'b1;
    @(posedge clk_i); #1;
    t_reset();
    t_mask_link();
    t_frame_sel();
    t_priority();
    t_tx();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule